// File: doc/BRIEF.md
# Vectored Priority Interrupt Controller

This block gathers interrupt requests from on-chip peripheral sources and from external request pins and presents them to a processor core as two active-low request lines. One is a fast request and the other a normal request. Each normal source has its own trigger mode, enable bit, 3-bit priority and 8-bit vector. Among the enabled, pending sources, the source with the highest priority is offered to the core. Software then reads that source's vector from a single register instead of polling. The fast request line is driven only by one dedicated external pin, which has its own trigger mode and enable bit.

Reading the vector acknowledges the source and pushes its priority onto an 8-deep nesting stack. While the stack is not empty, only strictly higher priorities can raise the normal request. A write to the end-of-interrupt register pops the stack. External pins are resynchronised by two flops before level or edge detection. Internal sources are assumed to be synchronous to the clock. The number of internal and external sources are parameters, with 4 internal and 6 external sources by default.

Register map (16-bit data, 6-bit word address):
- `0x00+s` is the configuration of source s. It holds the priority in [2:0], the trigger mode in [5:4] and the vector in [15:8].
- `0x20` is the enable word. Bit s enables source s, and bit NSRC enables the fast pin.
- `0x21` is the edge-clear register. Write 1s to clear edge latches, with bit NSRC for the fast pin.
- `0x22` is the vector register. Reading it returns the vector and acknowledges the source.
- `0x23` is end of interrupt. Any write pops the nesting stack.
- `0x24` holds the spurious vector.
- `0x25` holds the fast pin's trigger mode in [1:0].

Top module: `vpic_top`

## Requirements
- R1: When at least one enabled source is pending and the nesting stack is empty, irq_n is low. A vector read then returns, in bits [7:0], the vector of the pending source with the numerically highest priority.
- R2: Among pending sources of equal priority, the one with the lower source number is selected. Internal sources are numbered 0..N_INT-1 and external pins follow as N_INT.. .
- R3: A source whose enable bit (register 0x20, bit s) is 0 never drives irq_n low, whatever its input does. The enable word reads back 0 after reset.
- R4: fiq_n goes low only when the fast pin is pending and its enable bit (register 0x20, bit NSRC) is 1. Normal sources never drive fiq_n.
- R5: An internal source uses only mode bit [4]. A value of 0 means high-level and 1 means rising-edge, and mode bit [5] is ignored.
- R6: An external source, and the fast pin, use the mode values 0 = high-level, 1 = rising-edge, 2 = low-level and 3 = falling-edge.
- R7: If a vector read happens when no source is eligible, it returns the spurious vector from register 0x24 and does not change the nesting state.
- R8: An edge-mode source stays pending after its input returns to idle. A vector read that selects it clears its latch, and so does writing a 1 to its bit in register 0x21. The fast pin's latch is cleared only through register 0x21.
- R9: After a vector read acknowledges a source at priority P, irq_n is asserted only for eligible sources with priority strictly above P. The stack holds 8 levels.
- R10: A write to register 0x23 pops the nesting stack and restores the previous priority level, or no level when the stack empties.
- R11: After reset, irq_n and fiq_n are 1. Both outputs are registered.
- R12: An internal level source reaches irq_n one clock after the input changes. An external pin reaches irq_n three clocks after it changes: two synchroniser flops and then the output register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| int_src | input | N_INT | Internal peripheral requests |
| ext_irq | input | N_EXT | External normal request pins |
| ext_fiq | input | 1 | External fast request pin |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (read side effects at the clock edge) |
| bus_addr | input | 6 | Register word address |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, valid while bus_rd is high |
| irq_n | output | 1 | Normal interrupt request, active low |
| fiq_n | output | 1 | Fast interrupt request, active low |

## Verification
The bench sweeps every pair of normal sources with priorities spread so that some pairs tie. A design that compared with greater-or-equal, or scanned from the top index, would return the wrong vector on the ties. Nesting is driven to full depth, and then one level is popped at a time. A controller that let equal priorities through, or restored the wrong level after a pop, would raise irq_n when it should stay quiet or stay quiet when it should raise. Each trigger mode is toggled both ways: edge latches must survive the input going idle and must clear only on acknowledge or on an explicit clear. Exact latency is checked on both an internal and an external path, which exposes a missing or extra synchroniser stage.

// File: rtl/vpic_pkg.sv
package vpic_pkg;
  typedef enum logic [1:0] {
    TRIG_HIGH = 2'd0,
    TRIG_RISE = 2'd1,
    TRIG_LOW  = 2'd2,
    TRIG_FALL = 2'd3
  } trig_mode_e;

  localparam int PRIO_W   = 3;
  localparam int NEST_LVL = 8;

  localparam int A_ENA  = 32;
  localparam int A_ECLR = 33;
  localparam int A_IVEC = 34;
  localparam int A_EOI  = 35;
  localparam int A_SPUR = 36;
  localparam int A_FMOD = 37;
endpackage

// File: rtl/vpic_trig.sv
module vpic_trig #(
  parameter bit EXTERNAL = 1'b1
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       raw,
  input  logic [1:0] mode,
  input  logic       clr,
  output logic       pend
);
  logic       cur;
  logic       prev_q;
  logic       latch_q, latch_d;
  logic [1:0] mode_eff;
  logic       is_edge, hit;

  generate
    if (EXTERNAL) begin : g_sync
      logic s1_q, s2_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          s1_q <= 1'b0;
          s2_q <= 1'b0;
        end else begin
          s1_q <= raw;
          s2_q <= s1_q;
        end
      end
      assign cur      = s2_q;
      assign mode_eff = mode;
    end else begin : g_direct
      assign cur      = raw;
      assign mode_eff = {1'b0, mode[0]};
    end
  endgenerate

  always_comb begin
    is_edge = mode_eff[0];
    hit     = mode_eff[1] ? (prev_q & ~cur) : (cur & ~prev_q);
    latch_d = latch_q;
    if (clr)             latch_d = 1'b0;
    if (is_edge && hit)  latch_d = 1'b1;
    pend = is_edge ? latch_q : (mode_eff[1] ? ~cur : cur);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q  <= 1'b0;
      latch_q <= 1'b0;
    end else begin
      prev_q  <= cur;
      latch_q <= latch_d;
    end
  end

  AST_EDGE_CLR: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && !(is_edge && hit)) |=> !latch_q); // R8
endmodule

// File: rtl/vpic_arb.sv
module vpic_arb #(
  parameter int NSRC   = 10,
  parameter int PRIO_W = 3,
  localparam int IDX_W = $clog2(NSRC)
) (
  input  logic [NSRC-1:0]   elig,
  input  logic [PRIO_W-1:0] prio [NSRC],
  output logic              found,
  output logic [IDX_W-1:0]  win_idx,
  output logic [PRIO_W-1:0] win_prio
);
  always_comb begin
    found    = 1'b0;
    win_idx  = '0;
    win_prio = '0;
    for (int i = 0; i < NSRC; i++) begin
      if (elig[i] && (!found || prio[i] > win_prio)) begin
        found    = 1'b1;
        win_idx  = IDX_W'(i);
        win_prio = prio[i];
      end
    end
  end
endmodule

// File: rtl/vpic_nest.sv
module vpic_nest #(
  parameter int DEPTH  = 8,
  parameter int PRIO_W = 3,
  localparam int CNT_W = $clog2(DEPTH + 1),
  localparam int PTR_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              push,
  input  logic              pop,
  input  logic [PRIO_W-1:0] push_prio,
  output logic              active,
  output logic [PRIO_W-1:0] cur_prio
);
  logic [PRIO_W-1:0] stk_q [DEPTH];
  logic [CNT_W-1:0]  depth_q, depth_d;
  logic [CNT_W-1:0]  top_c;
  logic              do_push, do_pop;

  always_comb begin
    do_push = push && (depth_q < CNT_W'(DEPTH));
    do_pop  = pop && !push && (depth_q != '0);
    depth_d = depth_q;
    if (do_push)     depth_d = depth_q + CNT_W'(1);
    else if (do_pop) depth_d = depth_q - CNT_W'(1);
    top_c    = depth_q - CNT_W'(1);
    active   = (depth_q != '0);
    cur_prio = active ? stk_q[top_c[PTR_W-1:0]] : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      depth_q <= '0;
      for (int i = 0; i < DEPTH; i++) stk_q[i] <= '0;
    end else begin
      depth_q <= depth_d;
      if (do_push) stk_q[depth_q[PTR_W-1:0]] <= push_prio;
    end
  end

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> (depth_q < CNT_W'(DEPTH))); // R9
  AST_PUSH_HIGHER: assert property (@(posedge clk) disable iff (!rst_n)
    (push && active) |-> (push_prio > cur_prio)); // R9
endmodule

// File: rtl/vpic_top.sv
module vpic_top
  import vpic_pkg::*;
#(
  parameter int N_INT  = 4,
  parameter int N_EXT  = 6,
  parameter int ADDR_W = 6,
  parameter int DATA_W = 16,
  localparam int NSRC  = N_INT + N_EXT,
  localparam int IDX_W = $clog2(NSRC),
  localparam int VEC_W = DATA_W - 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N_INT-1:0]  int_src,
  input  logic [N_EXT-1:0]  ext_irq,
  input  logic              ext_fiq,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              irq_n,
  output logic              fiq_n
);
  logic [PRIO_W-1:0] cfg_prio [NSRC];
  logic [1:0]        cfg_mode [NSRC];
  logic [VEC_W-1:0]  cfg_vec  [NSRC];
  logic [NSRC-1:0]   cfg_we;
  logic [NSRC:0]     ena_q;
  logic [VEC_W-1:0]  spur_q;
  logic [1:0]        fmode_q;
  logic              irq_n_q, fiq_n_q;

  logic              wr_ena, wr_eclr, wr_eoi, wr_spur, wr_fmod, rd_ivec;
  logic [NSRC-1:0]   src_raw, pend, clr, elig;
  logic              fast_pend, fast_clr;
  logic              found, req, ack;
  logic [IDX_W-1:0]  win_idx;
  logic [PRIO_W-1:0] win_prio;
  logic              nest_active;
  logic [PRIO_W-1:0] nest_prio;

  assign src_raw = {ext_irq, int_src};

  // address decode
  always_comb begin
    for (int i = 0; i < NSRC; i++)
      cfg_we[i] = bus_wr && (int'(bus_addr) == i);
    wr_ena  = bus_wr && (int'(bus_addr) == A_ENA);
    wr_eclr = bus_wr && (int'(bus_addr) == A_ECLR);
    wr_eoi  = bus_wr && (int'(bus_addr) == A_EOI);
    wr_spur = bus_wr && (int'(bus_addr) == A_SPUR);
    wr_fmod = bus_wr && (int'(bus_addr) == A_FMOD);
    rd_ivec = bus_rd && (int'(bus_addr) == A_IVEC);
  end

  // per-source trigger logic
  generate
    for (genvar s = 0; s < NSRC; s++) begin : g_src
      vpic_trig #(.EXTERNAL(s >= N_INT)) u_trig (
        .clk  (clk),
        .rst_n(rst_n),
        .raw  (src_raw[s]),
        .mode (cfg_mode[s]),
        .clr  (clr[s]),
        .pend (pend[s])
      );
    end
  endgenerate

  vpic_trig #(.EXTERNAL(1'b1)) u_fast (
    .clk  (clk),
    .rst_n(rst_n),
    .raw  (ext_fiq),
    .mode (fmode_q),
    .clr  (fast_clr),
    .pend (fast_pend)
  );

  assign elig = pend & ena_q[NSRC-1:0];

  vpic_arb #(.NSRC(NSRC), .PRIO_W(PRIO_W)) u_arb (
    .elig    (elig),
    .prio    (cfg_prio),
    .found   (found),
    .win_idx (win_idx),
    .win_prio(win_prio)
  );

  vpic_nest #(.DEPTH(NEST_LVL), .PRIO_W(PRIO_W)) u_nest (
    .clk      (clk),
    .rst_n    (rst_n),
    .push     (ack),
    .pop      (wr_eoi),
    .push_prio(win_prio),
    .active   (nest_active),
    .cur_prio (nest_prio)
  );

  always_comb begin
    req = found && (!nest_active || (win_prio > nest_prio));
    ack = rd_ivec && req;
    for (int i = 0; i < NSRC; i++)
      clr[i] = (ack && (win_idx == IDX_W'(i))) || (wr_eclr && bus_wdata[i]);
    fast_clr = wr_eclr && bus_wdata[NSRC];
  end

  // read mux
  always_comb begin
    bus_rdata = '0;
    if (int'(bus_addr) < NSRC) begin
      bus_rdata[PRIO_W-1:0]  = cfg_prio[bus_addr[IDX_W-1:0]];
      bus_rdata[5:4]         = cfg_mode[bus_addr[IDX_W-1:0]];
      bus_rdata[DATA_W-1:8]  = cfg_vec[bus_addr[IDX_W-1:0]];
    end else if (int'(bus_addr) == A_ENA) begin
      bus_rdata[NSRC:0] = ena_q;
    end else if (int'(bus_addr) == A_IVEC) begin
      bus_rdata[VEC_W-1:0] = req ? cfg_vec[win_idx] : spur_q;
    end else if (int'(bus_addr) == A_SPUR) begin
      bus_rdata[VEC_W-1:0] = spur_q;
    end else if (int'(bus_addr) == A_FMOD) begin
      bus_rdata[1:0] = fmode_q;
    end
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NSRC; i++) begin
        cfg_prio[i] <= '0;
        cfg_mode[i] <= TRIG_HIGH;
        cfg_vec[i]  <= '0;
      end
      ena_q   <= '0;
      spur_q  <= '0;
      fmode_q <= TRIG_HIGH;
      irq_n_q <= 1'b1;
      fiq_n_q <= 1'b1;
    end else begin
      for (int i = 0; i < NSRC; i++) begin
        if (cfg_we[i]) begin
          cfg_prio[i] <= bus_wdata[PRIO_W-1:0];
          cfg_mode[i] <= bus_wdata[5:4];
          cfg_vec[i]  <= bus_wdata[DATA_W-1:8];
        end
      end
      if (wr_ena)  ena_q   <= bus_wdata[NSRC:0];
      if (wr_spur) spur_q  <= bus_wdata[VEC_W-1:0];
      if (wr_fmod) fmode_q <= bus_wdata[1:0];
      irq_n_q <= ~req;
      fiq_n_q <= ~(fast_pend && ena_q[NSRC]);
    end
  end

  assign irq_n = irq_n_q;
  assign fiq_n = fiq_n_q;

  AST_IRQ_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_n |-> $past(|(pend & ena_q[NSRC-1:0]))); // R3
  AST_FIQ_SRC: assert property (@(posedge clk) disable iff (!rst_n)
    !fiq_n |-> $past(fast_pend && ena_q[NSRC])); // R4
endmodule

// File: tb/tb_vpic_top.sv
module tb_vpic_top;
  localparam int CLK_P = 10;
  localparam int NI = 4;
  localparam int NE = 6;
  localparam int NS = NI + NE;

  logic          clk, rst_n;
  logic [NI-1:0] int_src;
  logic [NE-1:0] ext_irq;
  logic          ext_fiq, bus_wr, bus_rd;
  logic [5:0]    bus_addr;
  logic [15:0]   bus_wdata, bus_rdata;
  logic          irq_n, fiq_n;

  int total = 0;
  int bad   = 0;

  vpic_top dut (
    .clk(clk), .rst_n(rst_n), .int_src(int_src), .ext_irq(ext_irq),
    .ext_fiq(ext_fiq), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_n(irq_n), .fiq_n(fiq_n)
  );

  initial clk = 1'b0;
  always #(CLK_P/2) clk = ~clk;

  task automatic chk(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic settle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input int a, input int d);
    bus_addr = 6'(a); bus_wdata = 16'(d); bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input int a, output int d);
    bus_addr = 6'(a); bus_rd = 1'b1;
    #1 d = int'(bus_rdata);
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic drive(input int s, input logic v);
    if (s < NI) int_src[s] = v;
    else        ext_irq[s-NI] = v;
  endtask

  function automatic int cfgw(input int v, input int m, input int p);
    return (v << 8) | (m << 4) | p;
  endfunction

  function automatic int sweep_prio(input int s);
    return (s * 3) % 8;
  endfunction

  initial begin
    int d, w;
    int_src = '0; ext_irq = '0; ext_fiq = 1'b0;
    bus_wr = 1'b0; bus_rd = 1'b0; bus_addr = '0; bus_wdata = '0;
    rst_n = 1'b0;
    settle(3);
    rst_n = 1'b1;
    settle(1);

    // R11 reset state
    chk("R11 irq_n reset", int'(irq_n), 1);
    chk("R11 fiq_n reset", int'(fiq_n), 1);
    rd(32, d); chk("R3 enable after reset", d, 0);

    wr(36, 'hEE);
    for (int s = 0; s < NS; s++) wr(s, cfgw('h40 + s, 0, sweep_prio(s)));
    rd(5, d); chk("R1 cfg readback", d, cfgw('h45, 0, 7));

    // R3 / R7 all masked
    for (int s = 0; s < NS; s++) drive(s, 1'b1);
    settle(5);
    chk("R3 masked irq_n", int'(irq_n), 1);
    rd(34, d); chk("R7 spurious vector", d, 'hEE);
    for (int s = 0; s < NS; s++) drive(s, 1'b0);
    settle(4);

    // R1 / R2 pair sweep
    for (int i = 0; i < NS; i++) begin
      for (int j = i + 1; j < NS; j++) begin
        drive(i, 1'b1); drive(j, 1'b1);
        wr(32, (1 << i) | (1 << j));
        settle(4);
        chk("R1 pair irq_n", int'(irq_n), 0);
        w = (sweep_prio(j) > sweep_prio(i)) ? j : i;
        rd(34, d);
        if (sweep_prio(i) == sweep_prio(j)) chk("R2 tie vector", d, 'h40 + w);
        else                                 chk("R1 pair vector", d, 'h40 + w);
        wr(35, 0);
        drive(i, 1'b0); drive(j, 1'b0);
        wr(32, 0);
        settle(4);
      end
    end
    chk("R7 stack empty spur", int'(irq_n), 1);
    rd(34, d); chk("R7 spurious after sweep", d, 'hEE);

    // R12 latency
    wr(0, cfgw('h40, 0, 0));
    wr(32, 1);
    settle(1);
    int_src[0] = 1'b1;
    #1 chk("R12 internal before edge", int'(irq_n), 1);
    @(negedge clk);
    chk("R12 internal one clock", int'(irq_n), 0);
    int_src[0] = 1'b0;
    settle(2);
    wr(32, 1 << 4);
    settle(1);
    ext_irq[0] = 1'b1;
    @(negedge clk); chk("R12 ext after 1", int'(irq_n), 1);
    @(negedge clk); chk("R12 ext after 2", int'(irq_n), 1);
    @(negedge clk); chk("R12 ext after 3", int'(irq_n), 0);

    // R6 external modes on source 4
    wr(4, cfgw('h44, 2, 2));
    settle(4);
    chk("R6 low-level input high", int'(irq_n), 1);
    ext_irq[0] = 1'b0; settle(4);
    chk("R6 low-level input low", int'(irq_n), 0);
    wr(4, cfgw('h44, 1, 2));
    settle(4);
    chk("R6 rise idle", int'(irq_n), 1);
    ext_irq[0] = 1'b1; settle(4);
    chk("R6 rise seen", int'(irq_n), 0);
    ext_irq[0] = 1'b0; settle(4);
    chk("R8 rise latched", int'(irq_n), 0);
    wr(33, 1 << 4); settle(2);
    chk("R8 clear register", int'(irq_n), 1);
    wr(4, cfgw('h44, 3, 2));
    ext_irq[0] = 1'b1; settle(4);
    chk("R6 fall on rising input", int'(irq_n), 1);
    ext_irq[0] = 1'b0; settle(4);
    chk("R6 fall seen", int'(irq_n), 0);
    rd(34, d); chk("R8 fall vector", d, 'h44);
    wr(35, 0); settle(2);
    chk("R8 ack cleared latch", int'(irq_n), 1);
    wr(4, cfgw('h44, 0, 2));
    settle(3);
    chk("R6 high-level idle", int'(irq_n), 1);

    // R5 internal modes on source 0
    wr(32, 1);
    wr(0, cfgw('h40, 1, 0));
    int_src[0] = 1'b1; @(negedge clk); int_src[0] = 1'b0;
    settle(3);
    chk("R5 internal rise latched", int'(irq_n), 0);
    rd(34, d); chk("R5 internal rise vector", d, 'h40);
    wr(35, 0); settle(2);
    chk("R8 internal ack clears", int'(irq_n), 1);
    wr(0, cfgw('h40, 2, 0));
    settle(2);
    chk("R5 mode bit5 ignored idle", int'(irq_n), 1);
    int_src[0] = 1'b1; settle(2);
    chk("R5 mode bit5 ignored high", int'(irq_n), 0);
    int_src[0] = 1'b0;
    wr(32, 0);
    settle(2);

    // R4 fast path
    for (int s = 0; s < NS; s++) drive(s, 1'b1);
    wr(32, (1 << NS) - 1);
    settle(4);
    chk("R4 normal sources leave fiq_n", int'(fiq_n), 1);
    for (int s = 0; s < NS; s++) drive(s, 1'b0);
    wr(32, 0);
    ext_fiq = 1'b1; settle(4);
    chk("R4 fast masked", int'(fiq_n), 1);
    wr(32, 1 << NS); settle(2);
    chk("R4 fast enabled", int'(fiq_n), 0);
    chk("R4 irq_n unaffected", int'(irq_n), 1);
    wr(37, 3); settle(3);
    chk("R6 fast fall idle", int'(fiq_n), 1);
    ext_fiq = 1'b0; settle(4);
    chk("R6 fast fall seen", int'(fiq_n), 0);
    rd(34, d); chk("R8 fast not cleared by ivec", d, 'hEE);
    settle(2);
    chk("R8 fast still latched", int'(fiq_n), 0);
    wr(33, 1 << NS); settle(2);
    chk("R8 fast clear register", int'(fiq_n), 1);
    wr(32, 0); wr(37, 0);

    // R9 / R10 nesting
    wr(0, cfgw('h40, 0, 3));
    wr(1, cfgw('h41, 0, 3));
    wr(2, cfgw('h42, 0, 5));
    int_src[0] = 1'b1; int_src[1] = 1'b1;
    wr(32, 3); settle(2);
    chk("R1 nest start", int'(irq_n), 0);
    rd(34, d); chk("R2 nest tie vector", d, 'h40);
    settle(2);
    chk("R9 equal blocked", int'(irq_n), 1);
    int_src[2] = 1'b1; wr(32, 7); settle(2);
    chk("R9 higher passes", int'(irq_n), 0);
    rd(34, d); chk("R9 higher vector", d, 'h42);
    settle(2);
    chk("R9 level 5 blocks", int'(irq_n), 1);
    int_src[2] = 1'b0;
    wr(35, 0); settle(2);
    chk("R10 pop to level 3", int'(irq_n), 1);
    wr(35, 0); settle(2);
    chk("R10 pop to empty", int'(irq_n), 0);
    rd(34, d); chk("R10 vector after pop", d, 'h40);
    wr(35, 0);
    int_src[0] = 1'b0; int_src[1] = 1'b0;
    wr(32, 0); settle(2);

    // R9 full depth
    for (int s = 0; s < 8; s++) wr(s, cfgw('h40 + s, 0, s));
    for (int s = 0; s < 8; s++) begin
      drive(s, 1'b1);
      wr(32, (1 << (s + 1)) - 1);
      settle(4);
      rd(34, d); chk("R9 depth push vector", d, 'h40 + s);
    end
    settle(2);
    chk("R9 full stack quiet", int'(irq_n), 1);
    rd(34, d); chk("R7 spur at full depth", d, 'hEE);
    for (int s = 0; s < 8; s++) wr(35, 0);
    settle(2);
    chk("R10 emptied stack", int'(irq_n), 0);
    rd(34, d); chk("R10 top after empty", d, 'h47);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(CLK_P * 150000);
    total++; bad++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule